// File: doc/BRIEF.md
# Clock Request Output Gating

This block sits between a clock generator's configuration register file and its output buffers. It takes the parallel configuration bits, two active-low clock-request pins shared among the PCI Express reference outputs, and an active-low CPU stop pin. From these it computes a run enable and a high-impedance flag for every differential pair. It also computes a run enable for every single-ended output. Clock synthesis, phase-locked loops, analog drivers and spread modulation live elsewhere.

There are six PCI Express reference pairs, numbered 7, 6, 5, 4, 3 and 0, and two graphics reference pairs. Each PCI Express pair has a master enable. Each can also be placed under request pin A, under request pin B, or under neither. The graphics pairs answer only to their own enable bits. Each of the three CPU pairs has an enable and a stop-enable bit that makes it obey the stop pin. A single mode bit chooses how every disabled differential pair behaves: it is either driven low or released to high impedance. Placing one pair under both request pins is flagged as a configuration error.

The pins pass through a two-flop synchronizer into the controlled clock domain. All output flags are updated on the falling edge of that clock, so each change lands in the low phase of the clock being gated.

Top module: `clkreq_gate`

## Requirements
- R1: While rst_ni is low, every enable output, every high-impedance flag and cfg_err_o are 0.
- R2: A PCI Express pair whose master enable bit is 0 has its enable output at 0, whatever the request pins do.
- R3: A pair assigned only to request A (sel_a=1, sel_b=0, master=1) runs while req_a_ni is low and stops while it is high.
- R4: A pair assigned only to request B (sel_b=1, sel_a=0, master=1) runs while req_b_ni is low and stops while it is high.
- R5: A pair assigned to neither request pin follows its master enable alone, and ignores both pins.
- R6: If any pair has sel_a and sel_b both set, cfg_err_o is 1. Such a pair runs only when both request pins are low and its master enable is 1.
- R7: Graphics pair k runs exactly when gfx_en_i[k] is 1. The request pins have no effect on it.
- R8: When hiz_mode_i is 1, a disabled differential pair (PCI Express, graphics or CPU) has its high-impedance flag at 1. When hiz_mode_i is 0, that flag is 0 and the pair is driven low. A running pair always has its flag at 0.
- R9: While cpu_stop_ni is low, CPU pair k stops if cpu_stop_en_i[k] is 1 and keeps running if it is 0. While the pin is high, stop-enable has no effect.
- R10: CPU pair k otherwise follows cpu_en_i[k]. Single-ended output k follows se_en_i[k]. The single-ended bits are ordered PCI, USB 48 MHz, REF0, REF1, REF2, with bit 0 = PCI.
- R11: A change on a request or stop pin reaches the outputs at the falling edge after the second rising edge that samples it. A change of a configuration bit reaches the outputs at the next falling edge.

Vector bit order for all PCI Express vectors: bit 5..0 = pair 7, 6, 5, 4, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controlled-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_a_ni | input | 1 | Request pin A, active low, asynchronous |
| req_b_ni | input | 1 | Request pin B, active low, asynchronous |
| cpu_stop_ni | input | 1 | CPU stop pin, active low, asynchronous |
| src_master_en_i | input | 6 | Master enable per PCI Express pair |
| src_sel_a_i | input | 6 | Assign pair to request A |
| src_sel_b_i | input | 6 | Assign pair to request B |
| gfx_en_i | input | 2 | Graphics pair enables |
| cpu_en_i | input | 3 | CPU pair enables |
| cpu_stop_en_i | input | 3 | CPU pair obeys stop pin when 1 |
| se_en_i | input | 5 | Single-ended output enables |
| hiz_mode_i | input | 1 | 1 = disabled pairs high impedance, 0 = driven low |
| src_en_o | output | 6 | PCI Express pair run enables |
| src_hiz_o | output | 6 | PCI Express pair high-impedance flags |
| gfx_en_o | output | 2 | Graphics pair run enables |
| gfx_hiz_o | output | 2 | Graphics pair high-impedance flags |
| cpu_en_o | output | 3 | CPU pair run enables |
| cpu_hiz_o | output | 3 | CPU pair high-impedance flags |
| se_en_o | output | 5 | Single-ended run enables |
| cfg_err_o | output | 1 | Dual request assignment detected |

## Verification
The bench targets the dual-assignment case. A design that let either pin alone enable the pair would run it with only one request low, and a design that did not decode the conflict would leave the error flag silent. It also targets pairs with no assignment while both pins are high; a design that gated every pair would stop them wrongly. It measures the pin latency edge by edge. A missing synchronizer stage shows up one edge early, and an output stage on the wrong edge shows up half a cycle off. Finally it combines a stopped CPU with mixed stop-enable bits and high-impedance mode, where an inverted stop-enable sense or a flag that leaks onto running pairs becomes visible.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;
  localparam int SRC_PAIRS = 6;
  localparam int GFX_PAIRS = 2;
  localparam int CPU_PAIRS = 3;
  localparam int SE_OUTS   = 5;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/clkreq_sync.sv
module clkreq_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/src_gate_lane.sv
module src_gate_lane (
  input  logic master_en_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic req_a_act_i,
  input  logic req_b_act_i,
  output logic run_o,
  output logic conflict_o
);
  logic a_ok, b_ok;
  // an assigned pin must be asserted; dual assignment therefore needs both
  assign a_ok       = !sel_a_i || req_a_act_i;
  assign b_ok       = !sel_b_i || req_b_act_i;
  assign run_o      = master_en_i && a_ok && b_ok;
  assign conflict_o = sel_a_i && sel_b_i;
endmodule

// File: rtl/cpu_gate_lane.sv
module cpu_gate_lane (
  input  logic en_i,
  input  logic stop_en_i,
  input  logic stop_act_i,
  output logic run_o
);
  assign run_o = en_i && !(stop_en_i && stop_act_i);
endmodule

// File: rtl/lowphase_stage.sv
module lowphase_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // update in the low phase of the gated clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate
  import clkreq_pkg::*;
#(
  parameter int N_SRC = SRC_PAIRS,
  parameter int N_GFX = GFX_PAIRS,
  parameter int N_CPU = CPU_PAIRS,
  parameter int N_SE  = SE_OUTS,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_a_ni,
  input  logic             req_b_ni,
  input  logic             cpu_stop_ni,
  input  logic [N_SRC-1:0] src_master_en_i,
  input  logic [N_SRC-1:0] src_sel_a_i,
  input  logic [N_SRC-1:0] src_sel_b_i,
  input  logic [N_GFX-1:0] gfx_en_i,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_CPU-1:0] cpu_stop_en_i,
  input  logic [N_SE-1:0]  se_en_i,
  input  logic             hiz_mode_i,
  output logic [N_SRC-1:0] src_en_o,
  output logic [N_SRC-1:0] src_hiz_o,
  output logic [N_GFX-1:0] gfx_en_o,
  output logic [N_GFX-1:0] gfx_hiz_o,
  output logic [N_CPU-1:0] cpu_en_o,
  output logic [N_CPU-1:0] cpu_hiz_o,
  output logic [N_SE-1:0]  se_en_o,
  output logic             cfg_err_o
);
  localparam int PIN_W = 3;
  localparam int OUT_W = 2*N_SRC + 2*N_GFX + 2*N_CPU + N_SE + 1;

  logic [PIN_W-1:0] pin_sync;
  logic req_a_act, req_b_act, stop_act;

  clkreq_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL({PIN_W{1'b1}})
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cpu_stop_ni, req_b_ni, req_a_ni}),
    .q_o    (pin_sync)
  );

  assign req_a_act = !pin_sync[0];
  assign req_b_act = !pin_sync[1];
  assign stop_act  = !pin_sync[2];

  logic [N_SRC-1:0] src_run, src_conf;
  logic [N_CPU-1:0] cpu_run;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    src_gate_lane u_lane (
      .master_en_i (src_master_en_i[i]),
      .sel_a_i     (src_sel_a_i[i]),
      .sel_b_i     (src_sel_b_i[i]),
      .req_a_act_i (req_a_act),
      .req_b_act_i (req_b_act),
      .run_o       (src_run[i]),
      .conflict_o  (src_conf[i])
    );
  end

  for (genvar k = 0; k < N_CPU; k++) begin : g_cpu
    cpu_gate_lane u_lane (
      .en_i       (cpu_en_i[k]),
      .stop_en_i  (cpu_stop_en_i[k]),
      .stop_act_i (stop_act),
      .run_o      (cpu_run[k])
    );
  end

  logic [N_SRC-1:0] src_hiz_n;
  logic [N_GFX-1:0] gfx_hiz_n;
  logic [N_CPU-1:0] cpu_hiz_n;

  assign src_hiz_n = ~src_run  & {N_SRC{hiz_mode_i}};
  assign gfx_hiz_n = ~gfx_en_i & {N_GFX{hiz_mode_i}};
  assign cpu_hiz_n = ~cpu_run  & {N_CPU{hiz_mode_i}};

  logic [OUT_W-1:0] stage_d, stage_q;

  assign stage_d = {|src_conf, se_en_i, cpu_hiz_n, cpu_run,
                    gfx_hiz_n, gfx_en_i, src_hiz_n, src_run};

  lowphase_stage #(.W(OUT_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stage_d),
    .q_o    (stage_q)
  );

  assign {cfg_err_o, se_en_o, cpu_hiz_o, cpu_en_o,
          gfx_hiz_o, gfx_en_o, src_hiz_o, src_en_o} = stage_q;

  // checks on the registered outputs, clocked at the update edge
  for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
    AST_MASTER_OFF: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !src_master_en_i[i] |=> !src_en_o[i]); // R2
    AST_OFF_HIZ: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!src_master_en_i[i] && hiz_mode_i) |=> src_hiz_o[i]); // R8
    AST_FREE_PAIR: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (src_master_en_i[i] && !src_sel_a_i[i] && !src_sel_b_i[i]) |=> src_en_o[i]); // R5
  end

  for (genvar k = 0; k < N_CPU; k++) begin : g_cpu_chk
    AST_CPU_FREE_RUN: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (cpu_en_i[k] && !cpu_stop_en_i[k]) |=> cpu_en_o[k]); // R9
  end

  AST_GFX_PLAIN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (gfx_en_o == $past(gfx_en_i))); // R7
  AST_DUAL_FLAG: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (|(src_sel_a_i & src_sel_b_i)) |=> cfg_err_o); // R6
  AST_RUN_NOT_HIZ: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((src_en_o & src_hiz_o) == '0) && ((cpu_en_o & cpu_hiz_o) == '0)); // R8
endmodule

// File: tb/tb_clkreq_gate.sv
module tb_clkreq_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RAND = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_a, req_b, stop_n, mode;
  logic [5:0] m_en, sel_a, sel_b, o_src_en, o_src_hiz;
  logic [1:0] g_en, o_gfx_en, o_gfx_hiz;
  logic [2:0] c_en, c_sen, o_cpu_en, o_cpu_hiz;
  logic [4:0] s_en, o_se_en;
  logic o_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkreq_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_a_ni(req_a), .req_b_ni(req_b),
    .cpu_stop_ni(stop_n), .src_master_en_i(m_en), .src_sel_a_i(sel_a),
    .src_sel_b_i(sel_b), .gfx_en_i(g_en), .cpu_en_i(c_en),
    .cpu_stop_en_i(c_sen), .se_en_i(s_en), .hiz_mode_i(mode),
    .src_en_o(o_src_en), .src_hiz_o(o_src_hiz), .gfx_en_o(o_gfx_en),
    .gfx_hiz_o(o_gfx_hiz), .cpu_en_o(o_cpu_en), .cpu_hiz_o(o_cpu_hiz),
    .se_en_o(o_se_en), .cfg_err_o(o_err)
  );

  function automatic logic [27:0] actual();
    return {o_err, o_se_en, o_cpu_hiz, o_cpu_en, o_gfx_hiz, o_gfx_en, o_src_hiz, o_src_en};
  endfunction

  // expected outputs from the requirements, for given pin levels
  function automatic logic [27:0] model(input logic ra, input logic rb, input logic st);
    logic [5:0] se, sh;
    logic [2:0] ce, ch;
    logic [1:0] gh;
    logic err;
    for (int i = 0; i < 6; i++) begin
      if (!m_en[i]) se[i] = 1'b0;                       // R2
      else if (sel_a[i] && sel_b[i]) se[i] = !ra && !rb; // R6
      else if (sel_a[i]) se[i] = !ra;                    // R3
      else if (sel_b[i]) se[i] = !rb;                    // R4
      else se[i] = 1'b1;                                 // R5
      sh[i] = !se[i] && mode;                            // R8
    end
    for (int k = 0; k < 3; k++) begin
      ce[k] = c_en[k] && !(c_sen[k] && !st);             // R9 R10
      ch[k] = !ce[k] && mode;
    end
    for (int k = 0; k < 2; k++) gh[k] = !g_en[k] && mode; // R7
    err = |(sel_a & sel_b);
    return {err, s_en, ch, ce, gh, g_en, sh, se};
  endfunction

  task automatic chk(input string tag, input logic [27:0] exp);
    n_chk++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  // inputs assigned just after a falling edge; settle over the full pin latency
  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic defaults();
    req_a = 1; req_b = 1; stop_n = 1; mode = 0;
    m_en = '1; sel_a = '0; sel_b = '0; g_en = '1; c_en = '1; c_sen = '1; s_en = '1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51c0_77aa));
    defaults();
    repeat (3) @(negedge clk);
    #1 chk("R1 reset", 28'h0);
    rst_n = 1;
    @(negedge clk); #1;
    settle();
    chk("R5 default all run, pins high", model(req_a, req_b, stop_n));

    sel_a[2] = 1; settle();
    chk("R3 req A high stops pair", model(1, 1, 1));
    if (o_src_en[2] !== 1'b0) begin n_bad++; $display("FAIL R3 actual=%b expected=0", o_src_en[2]); end
    n_chk++;

    // R11 pin latency: no change after one rising edge, change after two
    req_a = 0;
    @(posedge clk); @(negedge clk); #1;
    chk("R11 pin not yet visible", model(1, 1, 1));
    @(posedge clk); @(negedge clk); #1;
    chk("R11 pin visible after two edges", model(0, 1, 1));
    chk("R3 req A low runs pair", model(req_a, req_b, stop_n));

    // R11 register latency: one falling edge
    m_en[4] = 0;
    @(negedge clk); #1;
    chk("R11 config bit next falling edge", model(req_a, req_b, stop_n));
    chk("R2 master off with request low", model(req_a, req_b, stop_n));

    sel_b[0] = 1; settle();
    chk("R4 req B high stops pair", model(req_a, req_b, stop_n));
    req_b = 0; settle();
    chk("R4 req B low runs pair", model(req_a, req_b, stop_n));

    mode = 1; req_b = 1; settle();
    chk("R8 disabled pairs high impedance", model(req_a, req_b, stop_n));

    defaults(); sel_a[1] = 1; sel_b[1] = 1; req_a = 0; settle();
    chk("R6 dual assign one pin low", model(req_a, req_b, stop_n));
    req_b = 0; settle();
    chk("R6 dual assign both low", model(req_a, req_b, stop_n));
    req_a = 1; settle();
    chk("R6 dual assign only B low", model(req_a, req_b, stop_n));

    defaults(); g_en = 2'b10; mode = 1; settle();
    chk("R7 graphics ignores requests", model(req_a, req_b, stop_n));
    req_a = 0; req_b = 0; settle();
    chk("R7 graphics with requests low", model(req_a, req_b, stop_n));

    defaults(); stop_n = 0; c_sen = 3'b101; mode = 1; settle();
    chk("R9 stop with mixed stop-enable", model(req_a, req_b, stop_n));
    stop_n = 1; settle();
    chk("R9 stop released", model(req_a, req_b, stop_n));

    defaults(); c_en = 3'b011; s_en = 5'b10101; settle();
    chk("R10 cpu and single-ended enables", model(req_a, req_b, stop_n));

    for (int n = 0; n < N_RAND; n++) begin
      req_a = 1'($urandom); req_b = 1'($urandom); stop_n = 1'($urandom);
      mode = 1'($urandom); m_en = 6'($urandom | $urandom);
      sel_a = 6'($urandom); sel_b = 6'($urandom & $urandom & $urandom);
      g_en = 2'($urandom); c_en = 3'($urandom); c_sen = 3'($urandom);
      s_en = 5'($urandom);
      settle();
      chk("R2-R10 random", model(req_a, req_b, stop_n));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule